// File: doc/BRIEF.md
# Bit-Serial Configuration Memory Read Controller

This block models the read side of a serial configuration memory. The memory streams its contents to a programmable logic device, one bit per clock. An internal address counter selects the bit shown on the data output. The counter steps forward on every rising clock edge while the chip is selected and its output is enabled.

One input pin serves as both counter reset and output enable. A parameter sets which level of that pin means reset. The other level means output enabled.

When the last stored bit has been clocked past, the block raises a sticky flag and drives its cascade output low. That output selects the next memory in a chain, so several devices can form one continuous stream.

The stored contents come from a packed parameter vector. Bit `i` of that vector is the bit read at address `i`. The depth is a parameter. Production-sized values such as 36,288, 65,536, 131,072 and 262,144 bits are supported. The default is kept small.

Top module: `cfgp_reader`

## Requirements
- R1: While the reset/enable pin is at its reset level, the counter is held at 0 on every clock edge. The data output is undriven (`data_oe`=0) and `ceo_n` is 1. After release, the first bit shown is address 0.
- R2: Counting requires `ce_n`=0 and the pin at its enable level. Under those conditions, each rising edge of `clk` advances the address by one. `data_out` shows `CONTENT[addr]` combinationally while `data_oe`=1.
- R3: While `ce_n`=1, the address is frozen, `data_oe`=0 and `standby`=1. When `ce_n` returns to 0, reading resumes at the same address.
- R4: `ceo_n` first goes low after exactly DEPTH advancing edges. From then on, `data_oe` is 0. `data_oe` and a low `ceo_n` are never active together.
- R5: Once the terminal count has been passed and the pin stays at its enable level, `ceo_n` equals `ce_n`.
- R6: Moving the pin to its reset level after the terminal count forces `ceo_n` high. It clears the past-count flag, and the next read starts again at address 0.
- R7: The address saturates one past the last address and never wraps. Any number of extra edges keeps `ceo_n`=0 and `data_oe`=0.
- R8: With `RST_ACTIVE_HIGH`=1, pin level 1 means reset. With `RST_ACTIVE_HIGH`=0, pin level 0 means reset. Both settings produce the same stream for the matching pin levels.
- R9: Two instances chained by connecting the first one's `ceo_n` to the second one's `ce_n` produce a gap-free stream of 2×DEPTH bits. Exactly one instance drives at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock; rising edges advance the address |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined reset / output-enable pin; polarity set by `RST_ACTIVE_HIGH` |
| data_out | output | 1 | Serial data bit at the current address (0 when undriven) |
| data_oe | output | 1 | High when `data_out` would actively drive the line |
| ceo_n | output | 1 | Cascade enable to the next device, active low |
| standby | output | 1 | High while the chip is deselected |

## Verification
The bench sweeps every address of a two-deep chain with distinct contents in each device. This shows whether the hand-off is seamless or slips, duplicates or overlaps a bit. A deselection pulse in the middle of the stream separates a frozen counter from one that keeps running. Toggling chip enable after the terminal count separates cascade-follows-enable from a latched cascade. Re-asserting reset then shows that the flag really clears. A third instance with inverted pin polarity receives the inverted pin and must reproduce the first device's stream bit for bit.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    // Decoded control state derived from the external pins.
    typedef struct packed {
        logic rst;   // counter reset request
        logic oe;    // output enable (inverse of rst)
        logic ce;    // chip selected
        logic run;   // ce && oe: counting permitted
    } cfgp_ctrl_t;

    function automatic logic pin_is_reset(input logic pin, input bit active_high);
        return active_high ? pin : ~pin;
    endfunction

    function automatic cfgp_ctrl_t build_ctrl(input logic rst_lvl, input logic ce_n);
        cfgp_ctrl_t c;
        c.rst = rst_lvl;
        c.oe  = ~rst_lvl;
        c.ce  = ~ce_n;
        c.run = c.oe & c.ce;
        return c;
    endfunction

endpackage

// File: rtl/cfgp_pin_decode.sv
module cfgp_pin_decode
    import cfgp_pkg::*;
#(
    parameter bit RST_ACTIVE_HIGH = 1'b1
) (
    input  logic       rst_oe,
    input  logic       ce_n,
    output cfgp_ctrl_t ctrl
);
    logic rst_lvl;

    generate
        if (RST_ACTIVE_HIGH) begin : g_rst_high
            assign rst_lvl = pin_is_reset(rst_oe, 1'b1);
        end else begin : g_rst_low
            assign rst_lvl = pin_is_reset(rst_oe, 1'b0);
        end
    endgenerate

    assign ctrl = build_ctrl(rst_lvl, ce_n);

endmodule

// File: rtl/cfgp_addr_counter.sv
module cfgp_addr_counter
    import cfgp_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  cfgp_ctrl_t    ctrl,
    output logic [AW-1:0] addr,
    output logic          past_tc
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW-1:0] TOP  = AW'(DEPTH);

    always_ff @(posedge clk) begin
        if (ctrl.rst) begin
            addr    <= '0;
            past_tc <= 1'b0;
        end else if (ctrl.run && !past_tc) begin
            addr <= addr + 1'b1;
            if (addr == LAST) past_tc <= 1'b1;
        end
    end

    // R1: reset holds the address at zero
    p_hold_zero_r1: assert property (@(posedge clk) ctrl.rst |=> (addr == '0 && !past_tc));
    // R3: deselected means frozen
    p_frozen_r3: assert property (@(posedge clk) disable iff (ctrl.rst)
        (!ctrl.ce && !$past(ctrl.rst)) |=> $stable(addr));
    // R2: single step per enabled edge
    p_step_r2: assert property (@(posedge clk) disable iff (ctrl.rst)
        (ctrl.run && !past_tc && !$past(ctrl.rst)) |=> (addr == $past(addr) + 1'b1));
    // R7: no wrap past the top
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (ctrl.rst)
        (past_tc && !$past(ctrl.rst)) |=> (past_tc && addr == TOP));

endmodule

// File: rtl/cfgp_bit_store.sv
module cfgp_bit_store #(
    parameter int               DEPTH   = 512,
    parameter logic [DEPTH-1:0] CONTENT = '0,
    localparam int AW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr,
    output logic          bit_val
);
    always_comb begin
        if (addr < AW'(DEPTH)) bit_val = CONTENT[addr[IW-1:0]];
        else                   bit_val = 1'b0;
    end

endmodule

// File: rtl/cfgp_reader.sv
module cfgp_reader
    import cfgp_pkg::*;
#(
    parameter int               DEPTH           = 512,
    parameter logic [DEPTH-1:0] CONTENT         = '0,
    parameter bit               RST_ACTIVE_HIGH = 1'b1,
    localparam int AW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic ce_n,
    input  logic rst_oe,
    output logic data_out,
    output logic data_oe,
    output logic ceo_n,
    output logic standby
);
    cfgp_ctrl_t    ctrl;
    logic [AW-1:0] addr;
    logic          past_tc;
    logic          cur_bit;

    cfgp_pin_decode #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_decode (
        .rst_oe (rst_oe),
        .ce_n   (ce_n),
        .ctrl   (ctrl)
    );

    cfgp_addr_counter #(.DEPTH(DEPTH)) u_counter (
        .clk     (clk),
        .ctrl    (ctrl),
        .addr    (addr),
        .past_tc (past_tc)
    );

    cfgp_bit_store #(.DEPTH(DEPTH), .CONTENT(CONTENT)) u_store (
        .addr    (addr),
        .bit_val (cur_bit)
    );

    assign data_oe  = ctrl.run & ~past_tc;
    assign data_out = data_oe & cur_bit;
    assign ceo_n    = ~(ctrl.run & past_tc);
    assign standby  = ~ctrl.ce;

    // R4: never drive data while handing off
    p_exclusive_r4: assert property (@(posedge clk) disable iff (ctrl.rst)
        !(data_oe && !ceo_n));
    // R5: cascade low only while selected
    p_ceo_sel_r5: assert property (@(posedge clk) disable iff (ctrl.rst)
        !ceo_n |-> !ce_n);
    // R6: reset level forces cascade high
    p_ceo_reset_r6: assert property (@(posedge clk) ctrl.rst |-> (ceo_n && !data_oe));

endmodule

// File: tb/cfgp_reader_tb.sv
module cfgp_reader_tb;
    localparam int D = 32;
    localparam logic [D-1:0] PAT_A = 32'hB5C3_96E1;
    localparam logic [D-1:0] PAT_B = 32'h4E17_A2D9;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_pin = 1'b1;
    logic ce_n    = 1'b1;
    logic d1, oe1, ceo1, sb1, d2, oe2, ceo2, sb2, di, oei, ceoi, sbi;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    cfgp_reader #(.DEPTH(D), .CONTENT(PAT_A), .RST_ACTIVE_HIGH(1'b1)) u_dut (
        .clk(clk), .ce_n(ce_n), .rst_oe(rst_pin),
        .data_out(d1), .data_oe(oe1), .ceo_n(ceo1), .standby(sb1));

    cfgp_reader #(.DEPTH(D), .CONTENT(PAT_B), .RST_ACTIVE_HIGH(1'b1)) u_dut2 (
        .clk(clk), .ce_n(ceo1), .rst_oe(rst_pin),
        .data_out(d2), .data_oe(oe2), .ceo_n(ceo2), .standby(sb2));

    cfgp_reader #(.DEPTH(D), .CONTENT(PAT_A), .RST_ACTIVE_HIGH(1'b0)) u_inv (
        .clk(clk), .ce_n(ce_n), .rst_oe(~rst_pin),
        .data_out(di), .data_oe(oei), .ceo_n(ceoi), .standby(sbi));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic stream_bit(input int k);
        if (k < D) return PAT_A[k];
        return PAT_B[k - D];
    endfunction

    task automatic check_pos(input int k);
        logic merged;
        merged = (oe1 & d1) | (oe2 & d2);
        chk(oe1 == (k < D), "R4 oe1", oe1, k < D);
        chk(oe2 == (k >= D && k < 2*D), "R9 oe2", oe2, k >= D && k < 2*D);
        chk(ceo1 == !(k >= D), "R4 ceo1", ceo1, !(k >= D));
        chk(ceo2 == !(k >= 2*D), "R7 ceo2", ceo2, !(k >= 2*D));
        if (k < 2*D) chk(merged == stream_bit(k), "R2/R9 stream", merged, stream_bit(k));
        chk(!(oe1 && oe2), "R9 single driver", oe1 + oe2, 1);
        chk(oei == oe1 && (!oei || di == PAT_A[k]), "R8 inverted polarity", di, (k < D) ? PAT_A[k] : 0);
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) tick();
        ce_n = 1'b0;
        repeat (2) tick();
        #1;
        // R1 reset state while selected
        chk(!oe1 && !oei, "R1 data undriven", oe1, 0);
        chk(ceo1 && ceo2, "R1 ceo high", ceo1, 1);
        chk(!sb1, "R3 standby low when selected", sb1, 0);
        tick();
        rst_pin = 1'b0;
        #1;
        chk(oe1 && d1 == PAT_A[0], "R1 starts at address 0", d1, PAT_A[0]);
        k = 0;
        while (k < 2*D + 6) begin
            check_pos(k);
            if (k == 10) begin
                // R3 deselect mid-stream
                tick(); ce_n = 1'b1; #1;
                for (int j = 0; j < 3; j++) begin
                    chk(!oe1 && sb1 && ceo1, "R3 deselected", oe1, 0);
                    tick(); #1;
                end
                ce_n = 1'b0; #1;
                chk(oe1 && d1 == PAT_A[11], "R3 resumes at same address", d1, PAT_A[11]);
                k = 11;
                continue;
            end
            tick(); #1;
            k++;
        end
        // R5 cascade follows enable after terminal count
        ce_n = 1'b1; #1;
        chk(ceo1 == 1'b1 && sb2, "R5 ceo follows ce high", ceo1, 1);
        tick(); #1;
        ce_n = 1'b0; #1;
        chk(ceo1 == 1'b0 && !oe1, "R5 ceo follows ce low", ceo1, 0);
        // R7 no wrap after many edges
        repeat (D + 5) tick();
        #1;
        chk(!ceo1 && !oe1 && !oe2, "R7 saturated", oe1, 0);
        // R6 reset after terminal count
        rst_pin = 1'b1; #1;
        chk(ceo1 && !oe1, "R6 ceo high on reset level", ceo1, 1);
        tick(); tick(); #1;
        chk(ceo1 && ceo2, "R6 ceo held high", ceo1, 1);
        rst_pin = 1'b0; #1;
        chk(oe1 && ceo1 && d1 == PAT_A[0], "R6 restart at address 0", d1, PAT_A[0]);
        tick(); #1;
        chk(oe1 && d1 == PAT_A[1], "R2 step after restart", d1, PAT_A[1]);
        chk(oei && di == PAT_A[1], "R8 inverted restart", di, PAT_A[1]);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule